// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block turns one of four interrupt sources into the entry into a service routine. A division fault, a non-maskable request, a maskable request carrying its own 8-bit type, and a single-step event are examined while the block is idle. One of them is picked by fixed priority. The block then captures the processor's current stack segment, stack pointer, code segment, instruction pointer and flag word.

It pushes three words through a word-wide memory port that waits on an acknowledge: the flag word, then the code segment, then the instruction pointer. It next fetches the routine's instruction pointer and code segment from the vector table at the bottom of memory. It then presents the new stack pointer, code segment, instruction pointer and the masked flag word, together with a one-cycle completion pulse.

The surrounding core holds the captured values until the pulse and then loads them.

Top module: `intr_entry_seq`

## Requirements
- R1: After reset, `done`, `mem_req` and `mem_we` are low and `sp_out`, `cs_out`, `ip_out` and `flags_out` are zero.
- R2: When several sources are present in the same idle cycle, priority is division fault, then non-maskable, then maskable (if enabled), then single step.
- R3: The maskable request is taken only when bit 9 (interrupt enable) of `flags_in` is 1. When that bit is 0 the request alone causes no memory access and no `done`. The division fault and non-maskable sources are taken whatever bit 9 holds.
- R4: Types are fixed by source: division fault is type 0, single step is type 1, non-maskable is type 2. The maskable type is `intr_type`.
- R5: The three stack writes occur in the order flag word, code segment, instruction pointer. Each write goes to physical address `ss*16 + sp'`, where `sp'` is the stack pointer already lowered by 2 for that write, giving `sp-2`, `sp-4` and `sp-6` in turn.
- R6: After the writes, the instruction pointer is read from physical address `type*4` and the code segment from `type*4+2`. These appear on `ip_out` and `cs_out`.
- R7: At `done`, `sp_out` equals the captured stack pointer minus 6, and `flags_out` equals the captured flag word with bit 9 (interrupt enable) and bit 8 (trap) cleared. The pushed flag word keeps its original value.
- R8: `done` is high for exactly one cycle. With zero-wait memory it appears 6 cycles after the cycle in which the request is presented. Requests presented while a sequence runs are ignored.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady.
- R10: The stack pointer wraps modulo 2^16 and physical addresses wrap modulo 2^20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_err | input | 1 | Division fault event |
| nmi_req | input | 1 | Non-maskable request |
| intr_req | input | 1 | Maskable request |
| intr_type | input | 8 | Type for the maskable request |
| step_evt | input | 1 | Single-step event |
| ss_in | input | 16 | Current stack segment |
| sp_in | input | 16 | Current stack pointer |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| flags_in | input | 16 | Current flag word (bit 9 enable, bit 8 trap) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes on this edge |
| sp_out | output | 16 | Updated stack pointer |
| cs_out | output | 16 | Routine code segment |
| ip_out | output | 16 | Routine instruction pointer |
| flags_out | output | 16 | Flag word with enable and trap cleared |
| done | output | 1 | One-cycle completion pulse |

## Verification
Each source is tried alone, with the enable bit both set and cleared, so that a wrong type constant or a missing mask shows up as a wrong vector fetch. Combinations of sources separate the priority orders: all four together, the three lower sources without the division fault, and maskable plus single step with and without enable. A segment near the top of memory with a small stack pointer exposes missing 16-bit and 20-bit wrapping. Runs with an acknowledge that stalls every other cycle, and a request arriving mid-sequence, show whether the port holds steady and whether a running entry can be disturbed.

// File: rtl/ivs_pkg.sv
package ivs_pkg;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 20;
  localparam int TYPE_W   = 8;
  localparam int SRC_N    = 4;
  localparam int IF_BIT   = 9;
  localparam int TF_BIT   = 8;
  localparam int PUSH_N   = 3;
  localparam int WORD_B   = DATA_W / 8;

  localparam logic [TYPE_W-1:0] TYPE_DIV  = 8'd0;
  localparam logic [TYPE_W-1:0] TYPE_STEP = 8'd1;
  localparam logic [TYPE_W-1:0] TYPE_NMI  = 8'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_F, ST_PUSH_C, ST_PUSH_I, ST_RD_IP, ST_RD_CS, ST_DONE
  } seq_st_t;

  typedef struct packed {
    logic [DATA_W-1:0] ss;
    logic [DATA_W-1:0] sp;
    logic [DATA_W-1:0] cs;
    logic [DATA_W-1:0] ip;
    logic [DATA_W-1:0] flags;
  } ctx_t;

  function automatic logic [ADDR_W-1:0] stack_phys(input logic [DATA_W-1:0] seg,
                                                   input logic [DATA_W-1:0] off);
    logic [ADDR_W-1:0] s;
    logic [ADDR_W-1:0] o;
    s = {seg, 4'b0000};
    o = {{(ADDR_W-DATA_W){1'b0}}, off};
    return s + o;
  endfunction

  function automatic logic [ADDR_W-1:0] vec_phys(input logic [TYPE_W-1:0] typ,
                                                 input logic hi_word);
    return {{(ADDR_W-TYPE_W-2){1'b0}}, typ, hi_word, 1'b0};
  endfunction

  function automatic logic [DATA_W-1:0] entry_flags(input logic [DATA_W-1:0] f);
    logic [DATA_W-1:0] r;
    r = f;
    r[IF_BIT] = 1'b0;
    r[TF_BIT] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/ivs_arbiter.sv
module ivs_arbiter
  import ivs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              div_err,
  input  logic              nmi_req,
  input  logic              intr_req,
  input  logic [TYPE_W-1:0] intr_type,
  input  logic              step_evt,
  input  logic              int_en,
  output logic              grant,
  output logic [SRC_N-1:0]  grant_vec,
  output logic [TYPE_W-1:0] grant_type
);
  logic [SRC_N-1:0] raw;
  logic [TYPE_W-1:0] src_type [SRC_N];

  // index order is the priority order: lowest index wins
  assign raw = {step_evt, intr_req & int_en, nmi_req, div_err};
  assign src_type[0] = TYPE_DIV;
  assign src_type[1] = TYPE_NMI;
  assign src_type[2] = intr_type;
  assign src_type[3] = TYPE_STEP;

  always_comb begin
    grant_vec  = '0;
    grant_type = '0;
    if (enable) begin
      for (int i = SRC_N - 1; i >= 0; i--) begin
        if (raw[i]) begin
          grant_vec  = '0;
          grant_vec[i] = 1'b1;
          grant_type = src_type[i];
        end
      end
    end
  end
  assign grant = |grant_vec;

  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));
  a_r2_fault_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && div_err) |-> grant_vec[0]);
  a_r3_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vec[2] |-> int_en);
  a_r3_nmi_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && nmi_req && !div_err) |-> grant_vec[1]);
endmodule

// File: rtl/ivs_seq.sv
module ivs_seq
  import ivs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TYPE_W-1:0] start_type,
  input  ctx_t              ctx_in,
  output logic              idle,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [DATA_W-1:0] sp_out,
  output logic [DATA_W-1:0] cs_out,
  output logic [DATA_W-1:0] ip_out,
  output logic [DATA_W-1:0] flags_out,
  output logic              done
);
  seq_st_t           st;
  ctx_t              ctx;
  logic [TYPE_W-1:0] typ;
  logic [DATA_W-1:0] sp_w;
  logic [DATA_W-1:0] ip_new;
  logic [DATA_W-1:0] sp_dec;
  logic              is_push;
  logic              is_read;
  logic              step_ok;

  assign sp_dec  = sp_w - DATA_W'(WORD_B);
  assign is_push = (st == ST_PUSH_F) || (st == ST_PUSH_C) || (st == ST_PUSH_I);
  assign is_read = (st == ST_RD_IP) || (st == ST_RD_CS);
  assign step_ok = (is_push || is_read) && mem_ack;
  assign idle    = (st == ST_IDLE);
  assign done    = (st == ST_DONE);
  assign mem_req = is_push || is_read;
  assign mem_we  = is_push;

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      ST_PUSH_F: begin mem_addr = stack_phys(ctx.ss, sp_dec); mem_wdata = ctx.flags; end
      ST_PUSH_C: begin mem_addr = stack_phys(ctx.ss, sp_dec); mem_wdata = ctx.cs;    end
      ST_PUSH_I: begin mem_addr = stack_phys(ctx.ss, sp_dec); mem_wdata = ctx.ip;    end
      ST_RD_IP:  mem_addr = vec_phys(typ, 1'b0);
      ST_RD_CS:  mem_addr = vec_phys(typ, 1'b1);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ctx       <= '0;
      typ       <= '0;
      sp_w      <= '0;
      ip_new    <= '0;
      sp_out    <= '0;
      cs_out    <= '0;
      ip_out    <= '0;
      flags_out <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          ctx  <= ctx_in;
          typ  <= start_type;
          sp_w <= ctx_in.sp;
          st   <= ST_PUSH_F;
        end
        ST_PUSH_F: if (step_ok) begin sp_w <= sp_dec; st <= ST_PUSH_C; end
        ST_PUSH_C: if (step_ok) begin sp_w <= sp_dec; st <= ST_PUSH_I; end
        ST_PUSH_I: if (step_ok) begin sp_w <= sp_dec; st <= ST_RD_IP;  end
        ST_RD_IP:  if (step_ok) begin ip_new <= mem_rdata; st <= ST_RD_CS; end
        ST_RD_CS:  if (step_ok) begin
          sp_out    <= sp_w;
          ip_out    <= ip_new;
          cs_out    <= mem_rdata;
          flags_out <= entry_flags(ctx.flags);
          st        <= ST_DONE;
        end
        default:   st <= ST_IDLE;
      endcase
    end
  end

  a_r9_port_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                               && $stable(mem_wdata)));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_req && !mem_we && mem_ack));
  a_r7_flags_masked: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!flags_out[IF_BIT] && !flags_out[TF_BIT]));
  a_r5_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> !(mem_req && mem_we));
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
  import ivs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_err,
  input  logic              nmi_req,
  input  logic              intr_req,
  input  logic [TYPE_W-1:0] intr_type,
  input  logic              step_evt,
  input  logic [DATA_W-1:0] ss_in,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] cs_in,
  input  logic [DATA_W-1:0] ip_in,
  input  logic [DATA_W-1:0] flags_in,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [DATA_W-1:0] sp_out,
  output logic [DATA_W-1:0] cs_out,
  output logic [DATA_W-1:0] ip_out,
  output logic [DATA_W-1:0] flags_out,
  output logic              done
);
  logic              seq_idle;
  logic              grant;
  logic [SRC_N-1:0]  grant_vec;
  logic [TYPE_W-1:0] grant_type;
  ctx_t              ctx_now;

  assign ctx_now = '{ss: ss_in, sp: sp_in, cs: cs_in, ip: ip_in, flags: flags_in};

  ivs_arbiter arb_i (
    .clk(clk), .rst_n(rst_n), .enable(seq_idle),
    .div_err(div_err), .nmi_req(nmi_req), .intr_req(intr_req),
    .intr_type(intr_type), .step_evt(step_evt), .int_en(flags_in[IF_BIT]),
    .grant(grant), .grant_vec(grant_vec), .grant_type(grant_type)
  );

  ivs_seq seq_i (
    .clk(clk), .rst_n(rst_n), .start(grant), .start_type(grant_type),
    .ctx_in(ctx_now), .idle(seq_idle),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .sp_out(sp_out), .cs_out(cs_out), .ip_out(ip_out),
    .flags_out(flags_out), .done(done)
  );

  a_r8_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_idle |-> !grant);
endmodule

// File: tb/intr_entry_seq_tb_top.sv
module intr_entry_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic div_err = 0, nmi_req = 0, intr_req = 0, step_evt = 0;
  logic [7:0]  intr_type = 0;
  logic [15:0] ss_in = 0, sp_in = 0, cs_in = 0, ip_in = 0, flags_in = 0;
  logic        mem_req, mem_we, mem_ack;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, sp_out, cs_out, ip_out, flags_out;
  logic        done;
  logic        stall = 0, stall_en = 0;

  intr_entry_seq dut_i (.*);

  logic [15:0] mem [logic [19:0]];
  assign mem_ack = mem_req & ~stall;
  always_comb mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 16'h0000;

  int n_chk = 0, n_bad = 0, nwr = 0, req_cnt = 0, done_cnt = 0;
  logic [19:0] wr_a [4];
  logic [15:0] wr_d [4];

  always @(posedge clk) begin
    if (mem_req) req_cnt++;
    if (done) done_cnt++;
    if (mem_req && mem_we && mem_ack) begin
      mem[mem_addr] = mem_wdata;
      if (nwr < 4) begin wr_a[nwr] = mem_addr; wr_d[nwr] = mem_wdata; end
      nwr++;
    end
  end
  always @(negedge clk) stall <= stall_en ? ~stall : 1'b0;

  function automatic logic [15:0] tbl_ip(input int t); return 16'hA004 | 16'(t << 4); endfunction
  function automatic logic [15:0] tbl_cs(input int t); return 16'h3000 + 16'(t); endfunction
  function automatic logic [19:0] stk(input logic [15:0] s, input int off);
    int a;
    a = (int'(s) * 16 + (off & 16'hFFFF)) % (1 << 20);
    return 20'(a);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // {div, nmi, intr, step, intr_type, ss, sp, cs, ip, flags, expected type}
  localparam logic [99:0] VEC [9] = '{
    {4'b1000, 8'h00, 16'h1000, 16'h0100, 16'h2222, 16'h0456, 16'h0000, 8'h00},
    {4'b0100, 8'h00, 16'h1200, 16'h0080, 16'h2300, 16'h0010, 16'h0300, 8'h02},
    {4'b0010, 8'h47, 16'h0800, 16'h0200, 16'h4444, 16'h1234, 16'h0283, 8'h47},
    {4'b0001, 8'h00, 16'h0900, 16'h0040, 16'h5555, 16'h0101, 16'h0100, 8'h01},
    {4'b1111, 8'h33, 16'h0A00, 16'h0100, 16'h6666, 16'h0202, 16'h0200, 8'h00},
    {4'b0111, 8'h33, 16'h0B00, 16'h0100, 16'h7777, 16'h0303, 16'h0200, 8'h02},
    {4'b0011, 8'h80, 16'h0C00, 16'h0100, 16'h8888, 16'h0404, 16'h0200, 8'h80},
    {4'b0011, 8'h80, 16'h0D00, 16'h0100, 16'h9999, 16'h0505, 16'h0100, 8'h01},
    {4'b0010, 8'hFF, 16'hFFFF, 16'h0002, 16'hAAAA, 16'h0606, 16'h0200, 8'hFF}
  };

  task automatic run_entry(input logic [99:0] v, input bit stalled, output int lat);
    nwr = 0; req_cnt = 0; done_cnt = 0;
    stall_en = stalled;
    {div_err, nmi_req, intr_req, step_evt} = v[99:96];
    intr_type = v[95:88];
    {ss_in, sp_in, cs_in, ip_in, flags_in} = v[87:8];
    @(negedge clk);
    {div_err, nmi_req, intr_req, step_evt} = 4'b0000;
    lat = 1;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    stall_en = 0;
  endtask

  task automatic check_entry(input logic [99:0] v, input string tg);
    logic [15:0] s, p, c, i, f;
    int t;
    {s, p, c, i, f} = v[87:8];
    t = int'(v[7:0]);
    chk(nwr == 3, {tg, " R5 write count"}, nwr, 3);
    chk(wr_a[0] == stk(s, int'(p) - 2) && wr_d[0] == f, {tg, " R5 flag push"}, int'(wr_a[0]), int'(stk(s, int'(p) - 2)));
    chk(wr_a[1] == stk(s, int'(p) - 4) && wr_d[1] == c, {tg, " R5 cs push"}, int'(wr_a[1]), int'(stk(s, int'(p) - 4)));
    chk(wr_a[2] == stk(s, int'(p) - 6) && wr_d[2] == i, {tg, " R5 ip push"}, int'(wr_a[2]), int'(stk(s, int'(p) - 6)));
    chk(ip_out == tbl_ip(t), {tg, " R6 R4 R2 new ip"}, int'(ip_out), int'(tbl_ip(t)));
    chk(cs_out == tbl_cs(t), {tg, " R6 R4 R2 new cs"}, int'(cs_out), int'(tbl_cs(t)));
    chk(sp_out == 16'((int'(p) - 6) & 16'hFFFF), {tg, " R7 R10 new sp"}, int'(sp_out), (int'(p) - 6) & 16'hFFFF);
    chk(flags_out == (f & 16'hFCFF), {tg, " R7 flags"}, int'(flags_out), int'(f & 16'hFCFF));
  endtask

  initial begin
    for (int w = 0; w < 200000; w++) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    int lat;
    for (int t = 0; t < 256; t++) begin
      mem[20'(t * 4)] = tbl_ip(t);
      mem[20'(t * 4 + 2)] = tbl_cs(t);
    end
    @(negedge clk);
    chk(done == 0 && mem_req == 0 && mem_we == 0, "R1 reset controls", int'({done, mem_req, mem_we}), 0);
    chk(sp_out == 0 && cs_out == 0 && ip_out == 0 && flags_out == 0, "R1 reset outputs",
        int'(sp_out | cs_out | ip_out | flags_out), 0);
    @(negedge clk); rst_n = 1; @(negedge clk);

    for (int k = 0; k < 9; k++) begin
      run_entry(VEC[k], 1'b0, lat);
      chk(lat == 6, $sformatf("vec%0d R8 latency", k), lat, 6);
      check_entry(VEC[k], $sformatf("vec%0d", k));
      @(negedge clk);
      chk(!done, $sformatf("vec%0d R8 pulse width", k), int'(done), 0);
      @(negedge clk);
    end

    // R9 stalling acknowledge: same results, longer run
    run_entry(VEC[2], 1'b1, lat);
    chk(lat > 6 && lat < 100, "R9 stalled latency", lat, 11);
    check_entry(VEC[2], "stall R9");
    repeat (3) @(negedge clk);

    // R3 maskable request with enable clear: nothing happens
    req_cnt = 0; done_cnt = 0;
    flags_in = 16'h0000; intr_req = 1; intr_type = 8'h20;
    @(negedge clk); intr_req = 0;
    repeat (10) @(negedge clk);
    chk(req_cnt == 0 && done_cnt == 0, "R3 masked request idle", req_cnt + done_cnt, 0);

    // R8 request during a running entry is ignored
    begin
      logic [99:0] v;
      v = VEC[1];
      nwr = 0; req_cnt = 0; done_cnt = 0;
      {div_err, nmi_req, intr_req, step_evt} = v[99:96];
      {ss_in, sp_in, cs_in, ip_in, flags_in} = v[87:8];
      @(negedge clk); nmi_req = 0;
      @(negedge clk); div_err = 1;
      @(negedge clk); div_err = 0;
      repeat (15) @(negedge clk);
      chk(req_cnt == 5 && done_cnt == 1, "R8 busy ignores request", req_cnt, 5);
      chk(ip_out == tbl_ip(2), "R8 first entry kept", int'(ip_out), int'(tbl_ip(2)));
    end
    finish_up();
  end
endmodule